// File: doc/BRIEF.md
# SDRAM Mode-Controlled Burst Datapath

This block is a synthesizable, device-side model of a single SDRAM data path. A command port carries one of four operations each clock: idle, load-mode, read or write. A load-mode command takes a 12-bit mode word that sets the burst length, the read latency in clocks (two or three) and whether writes burst or touch one location. Read and write commands carry a column address into a small internal word array that stands in for the memory.

A read returns a burst of words on a 16-bit data output with a separate drive-enable flag. The flag rises one edge before the controller's sampling edge for the first word, then stays high for one cycle per word. Burst addresses walk upward and wrap inside the aligned block of the burst length that holds the starting column. A write takes its first word with the command and one further word per clock for the rest of the burst, unless the mode word selects single-location writes. Mode words that use the reserved operating-mode bits or an unsupported latency code raise flags.

Top module: `sdram_burst_path`

## Requirements
- R1: After reset `dq_oe`, `mode_unsupported` and `latency_err` are 0, the burst length is 1, the latency is 2 and writes follow the burst length.
- R2: Mode bits [2:0] set the burst length: 000→1, 001→2, 010→4, 011→8; codes 100 to 111 give a burst of 1.
- R3: Mode bits [6:4] set the latency: 010→2 clocks, 011→3 clocks. Any other code keeps the previous latency and sets `latency_err`. The next load with a valid code clears the flag.
- R4: A load with mode bits [8:7] not both 0 sets `mode_unsupported`. A load with both 0 clears it.
- R5: For a READ (cmd_op 10) registered at edge n with latency m, `dq_oe` is 0 after edge n+m-2 (when the path was idle) and rises after edge n+m-1. The first word is on `dq_out` from then on, so it is valid at edge n+m. Each later word follows one clock after the previous one.
- R6: Word k of a burst of length BL that starts at column c comes from address (c & ~(BL-1)) | ((c+k) & (BL-1)).
- R7: `dq_oe` falls one clock after the last word of a read burst. A READ registered exactly BL clocks after the previous one keeps it high with no gap.
- R8: With mode bit 9 at 0, a WRITE (cmd_op 11) registered at edge n stores `wdata` sampled at edge n+k into burst address k, for k below BL.
- R9: With mode bit 9 at 1, a WRITE stores only the word given with the command. The `wdata` values on the following edges are not stored.
- R10: A READ registered while a write burst is in progress ends that burst. No word is stored at that edge or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | 00 idle, 01 load-mode, 10 read, 11 write |
| cmd_addr | input | 12 | Mode word for load-mode; column in the low COL_W bits for read and write |
| wdata | input | DQ_W | Write data for the current edge |
| dq_out | output | DQ_W | Read data |
| dq_oe | output | 1 | Output drive enable (low impedance) |
| mode_unsupported | output | 1 | Last mode word selected a reserved operating mode |
| latency_err | output | 1 | Last mode word carried an unsupported latency code |

## Verification
The bench goes after latency timing at both settings, and checks that the drive-enable is still low one edge early. A design off by one register would drive too soon or present the first word late. Bursts start in the middle of a block to catch a design that runs past the block boundary instead of wrapping. A READ issued back to back with a previous one catches a spurious drop of the drive-enable. Reserved burst and latency codes, single-location writes and a write burst cut short by a read each show up as wrong data read back, or as a latency that changed when it should have held.

// File: rtl/sdram_dp_pkg.sv
package sdram_dp_pkg;

    localparam int MODE_W = 12;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_READ  = 2'b10,
        OP_WRITE = 2'b11
    } sdram_op_e;

    // burst length code -> address mask (BL-1); reserved codes give 1
    function automatic logic [2:0] burst_mask(input logic [2:0] code);
        case (code)
            3'b001:  return 3'd1;
            3'b010:  return 3'd3;
            3'b011:  return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output logic [2:0]        bl_mask,
    output logic              cas3,
    output logic              wr_single,
    output logic              unsup,
    output logic              lat_err
);

    typedef struct packed {
        logic [2:0] bl_mask;
        logic       cas3;
        logic       wr_single;
        logic       unsup;
        logic       lat_err;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (load) begin
            mode_d.bl_mask   = burst_mask(word[2:0]);
            mode_d.unsup     = |word[8:7];
            mode_d.wr_single = word[9];
            case (word[6:4])
                3'b010: begin mode_d.cas3 = 1'b0; mode_d.lat_err = 1'b0; end
                3'b011: begin mode_d.cas3 = 1'b1; mode_d.lat_err = 1'b0; end
                default: mode_d.lat_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign bl_mask   = mode_q.bl_mask;
    assign cas3      = mode_q.cas3;
    assign wr_single = mode_q.wr_single;
    assign unsup     = mode_q.unsup;
    assign lat_err   = mode_q.lat_err;

    AST_BAD_CAS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[6:4] != 3'b010 && word[6:4] != 3'b011) |=> ($stable(cas3) && lat_err)); // R3

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [2:0]    len_mask,
    input  logic          stop,
    output logic          pend,
    output logic [AW-1:0] addr
);

    typedef struct packed {
        logic          pend;
        logic [2:0]    rem;
        logic [2:0]    mask;
        logic [AW-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;

    function automatic logic [AW-1:0] wrap_next(input logic [AW-1:0] a, input logic [2:0] m);
        logic [2:0] low;
        low = (a[2:0] & ~m) | ((a[2:0] + 3'd1) & m);
        return {a[AW-1:3], low};
    endfunction

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.pend = |len_mask;
            seq_d.rem  = len_mask;
            seq_d.mask = len_mask;
            seq_d.addr = wrap_next(start_addr, len_mask);
        end else if (stop) begin
            seq_d.pend = 1'b0;
        end else if (seq_q.pend) begin
            seq_d.addr = wrap_next(seq_q.addr, seq_q.mask);
            seq_d.rem  = seq_q.rem - 3'd1;
            seq_d.pend = (seq_q.rem != 3'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pend = seq_q.pend;
    assign addr = seq_q.addr;

    AST_WRAP_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !start) |=> (addr[AW-1:3] == $past(addr[AW-1:3]) &&
                              (addr[2:0] & ~seq_q.mask) == ($past(addr[2:0]) & ~seq_q.mask))); // R6

endmodule

// File: rtl/sdram_burst_path.sv
module sdram_burst_path
    import sdram_dp_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int DQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic [MODE_W-1:0] cmd_addr,
    input  logic [DQ_W-1:0]   wdata,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              mode_unsupported,
    output logic              latency_err
);

    localparam int DEPTH = 1 << COL_W;

    typedef struct packed {
        logic             s0_v;
        logic [COL_W-1:0] s0_a;
        logic             s1_v;
        logic [COL_W-1:0] s1_a;
        logic             oe;
        logic [DQ_W-1:0]  dq;
    } pipe_t;

    sdram_op_e        op;
    logic             is_ld, is_rd, is_wr;
    logic [COL_W-1:0] col;
    logic [2:0]       bl_mask, wr_mask;
    logic             cas3, wr_single;
    logic             rd_pend, wr_pend;
    logic [COL_W-1:0] rd_addr, wr_addr;
    logic             we;
    logic [COL_W-1:0] wa;
    logic             src_v;
    logic [COL_W-1:0] src_a;
    logic [DQ_W-1:0]  mem [DEPTH];
    pipe_t            pipe_d, pipe_q;
    logic             unused_bits;

    assign op          = sdram_op_e'(cmd_op);
    assign is_ld       = (op == OP_LOAD);
    assign is_rd       = (op == OP_READ);
    assign is_wr       = (op == OP_WRITE);
    assign col         = cmd_addr[COL_W-1:0];
    assign unused_bits = ^{cmd_addr[11:10], cmd_addr[3]};

    sdram_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (is_ld),
        .word      (cmd_addr),
        .bl_mask   (bl_mask),
        .cas3      (cas3),
        .wr_single (wr_single),
        .unsup     (mode_unsupported),
        .lat_err   (latency_err)
    );

    assign wr_mask = wr_single ? 3'd0 : bl_mask;

    sdram_burst_seq #(.AW(COL_W)) u_rd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (is_rd),
        .start_addr (col),
        .len_mask   (bl_mask),
        .stop       (1'b0),
        .pend       (rd_pend),
        .addr       (rd_addr)
    );

    sdram_burst_seq #(.AW(COL_W)) u_wr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (is_wr),
        .start_addr (col),
        .len_mask   (wr_mask),
        .stop       (is_rd),
        .pend       (wr_pend),
        .addr       (wr_addr)
    );

    // write port: first word from the command, the rest from the sequencer
    always_comb begin
        we = is_wr | (wr_pend & ~is_rd);
        wa = is_wr ? col : wr_addr;
    end

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wdata;
    end

    // read pipe: stage 0 holds the word address issued at the command edge,
    // stage 1 adds one clock for the longer latency
    always_comb begin
        pipe_d = pipe_q;
        if (is_rd) begin
            pipe_d.s0_v = 1'b1;
            pipe_d.s0_a = col;
        end else if (rd_pend) begin
            pipe_d.s0_v = 1'b1;
            pipe_d.s0_a = rd_addr;
        end else begin
            pipe_d.s0_v = 1'b0;
        end
        pipe_d.s1_v = pipe_q.s0_v;
        pipe_d.s1_a = pipe_q.s0_a;
        src_v       = cas3 ? pipe_q.s1_v : pipe_q.s0_v;
        src_a       = cas3 ? pipe_q.s1_a : pipe_q.s0_a;
        pipe_d.oe   = src_v;
        if (src_v) pipe_d.dq = mem[src_a];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dq_out = pipe_q.dq;
    assign dq_oe  = pipe_q.oe;

    AST_CL2_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !cas3) |-> ##2 dq_oe); // R5

    AST_CL3_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && cas3) |-> ##3 dq_oe); // R5

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && wr_single) |=> !wr_pend); // R9

    AST_READ_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> !wr_pend); // R10

endmodule

// File: tb/sdram_burst_path_bench.sv
module sdram_burst_path_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;

    typedef struct {
        int          at;
        logic        oe;
        logic [15:0] dq;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [11:0] cmd_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] dq_out;
    logic        dq_oe, mode_unsupported, latency_err;

    exp_t        q[$];
    exp_t        cur;
    logic [15:0] ref_mem [1 << COL_W];
    int          m_bl = 1, m_cl = 2;
    bit          m_single = 1'b0;
    bit          m_unsup = 1'b0, m_laterr = 1'b0;
    int          cyc = 0;
    int          checks = 0, errors = 0;

    sdram_burst_path #(.COL_W(COL_W), .DQ_W(16)) u_sdram_burst_path (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_op           (cmd_op),
        .cmd_addr         (cmd_addr),
        .wdata            (wdata),
        .dq_out           (dq_out),
        .dq_oe            (dq_oe),
        .mode_unsupported (mode_unsupported),
        .latency_err      (latency_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input logic oe, input logic [15:0] dq, input string req);
        exp_t e;
        int i = 0;
        e.at = at; e.oe = oe; e.dq = dq; e.req = req;
        while (i < q.size() && q[i].at <= at) i++;
        q.insert(i, e);
    endtask

    // monitor: compares scoreboard items in the cycle they fall due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            cur = q.pop_front();
            if (cur.at < cyc)
                chk(1'b0, {cur.req, " missed"}, cur.at, cyc);
            else if (cur.oe)
                chk(dq_oe === 1'b1 && dq_out === cur.dq, cur.req, {15'd0, dq_oe, dq_out}, {16'h0001, cur.dq});
            else
                chk(dq_oe === 1'b0, cur.req, {31'd0, dq_oe}, 32'd0);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_op = 2'b00; cmd_addr = '0; wdata = 16'hDEAD;
        end
    endtask

    function automatic int burst_addr(input int c, input int k, input int bl);
        int m = bl - 1;
        return (c & ~m) | ((c + k) & m);
    endfunction

    task automatic load(input logic [11:0] w);
        @(negedge clk);
        cmd_op = 2'b01; cmd_addr = w;
        case (w[2:0])
            3'b001: m_bl = 2;
            3'b010: m_bl = 4;
            3'b011: m_bl = 8;
            default: m_bl = 1;
        endcase
        if (w[6:4] == 3'b010) begin m_cl = 2; m_laterr = 1'b0; end
        else if (w[6:4] == 3'b011) begin m_cl = 3; m_laterr = 1'b0; end
        else m_laterr = 1'b1;
        m_unsup  = |w[8:7];
        m_single = w[9];
        idle(1);
        chk(mode_unsupported === m_unsup, "R4 unsupported flag", {31'd0, mode_unsupported}, {31'd0, m_unsup});
        chk(latency_err === m_laterr, "R3 latency error flag", {31'd0, latency_err}, {31'd0, m_laterr});
    endtask

    // ncyc edges of write data; burst continuation is NOP with new wdata
    task automatic wr(input int c, input logic [15:0] base, input int ncyc);
        int nw = m_single ? 1 : m_bl;
        @(negedge clk);
        cmd_op = 2'b11; cmd_addr = 12'(c); wdata = base;
        for (int k = 1; k < ncyc; k++) begin
            @(negedge clk);
            cmd_op = 2'b00; cmd_addr = '0; wdata = base + 16'(k);
        end
        for (int k = 0; k < nw && k < ncyc; k++)
            ref_mem[burst_addr(c, k, m_bl)] = base + 16'(k);
    endtask

    task automatic rd(input int c, input bit cont, input bit early);
        int n;
        @(negedge clk);
        cmd_op = 2'b10; cmd_addr = 12'(c);
        n = cyc + 1;
        if (early) push(n + m_cl - 2, 1'b0, '0, "R5 drive not early");
        for (int k = 0; k < m_bl; k++)
            push(n + m_cl - 1 + k, 1'b1, ref_mem[burst_addr(c, k, m_bl)], "R5/R6 read word");
        if (!cont) push(n + m_cl - 1 + m_bl, 1'b0, '0, "R7 release after burst");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(dq_oe === 1'b0, "R1 reset oe", {31'd0, dq_oe}, 0);
        chk(mode_unsupported === 1'b0, "R1 reset unsupported", {31'd0, mode_unsupported}, 0);
        chk(latency_err === 1'b0, "R1 reset latency_err", {31'd0, latency_err}, 0);
        rst_n = 1'b1;
        idle(2);

        // R1 defaults: burst 1, latency 2
        wr(5, 16'hA5A5, 1); idle(2);
        rd(5, 1'b0, 1'b1);  idle(6);

        // R8/R6: burst 8 writes, one aligned and one starting mid-block
        load(12'h023);
        wr(16, 16'h1000, 8); idle(2);
        wr(27, 16'h2000, 8); idle(2);
        rd(19, 1'b0, 1'b1);  idle(12);
        rd(27, 1'b0, 1'b1);  idle(12);

        // R5 latency 3, R7 back-to-back reads with burst 4
        load(12'h032);
        rd(30, 1'b1, 1'b1); idle(3);
        rd(17, 1'b0, 1'b0); idle(10);

        // R3: bad latency code keeps latency 3
        load(12'h052);
        rd(20, 1'b0, 1'b1); idle(10);

        // R2: reserved burst code gives 1, code 001 gives 2
        load(12'h025);
        rd(22, 1'b0, 1'b1); idle(6);
        load(12'h021);
        rd(17, 1'b0, 1'b1); idle(6);

        // R4: reserved operating mode set then cleared
        load(12'h0A3);
        load(12'h023);

        // R9: single-location writes
        wr(64, 16'h3000, 8); idle(2);
        load(12'h223);
        wr(66, 16'h4000, 8); idle(2);
        rd(64, 1'b0, 1'b1);  idle(12);

        // R10: read cuts a write burst after three words
        load(12'h023);
        wr(64, 16'h5000, 3);
        rd(16, 1'b0, 1'b0);  idle(12);
        rd(64, 1'b0, 1'b1);  idle(12);

        while (q.size() > 0) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule